// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block drives an active-low system reset from a digital "supply is above the trip level" indication and a free-running timebase strobe. While the supply indication is low, the reset output is held low without waiting for a clock edge. When the supply becomes good, the block counts timebase ticks. It lets reset go only after the supply has stayed good for a full hold-off interval. A dip below the trip level at any point during that count throws the count away. Counting starts again from zero once the supply is good again.

A watchdog expiry request, taken while the system is running, also pulls reset low for the same hold-off interval. A volatile cause flag records which kind of event produced the latest reset: it is set by a watchdog reset and cleared by a low-supply reset. Software can also set or clear it through two strobes. The hold-off length is a parameter counted in timebase ticks. With a 1 ms tick it gives the nominal 800 ms, and a bench can shrink it to a few ticks. The supply indication is expected to arrive already synchronous to `clk`.

The controller has four states. `ST_LOWV` means the supply is below the trip level. `ST_HOLD` is the hold-off after the supply recovers. `ST_RUN` means reset is released. `ST_WDOG` is the hold-off after a watchdog expiry. The transitions are:
- supply low, from any state, goes to `ST_LOWV`.
- In `ST_LOWV`, supply good goes to `ST_HOLD`.
- In `ST_HOLD`, hold-off done goes to `ST_RUN`.
- In `ST_RUN`, a watchdog expiry goes to `ST_WDOG`.
- In `ST_WDOG`, hold-off done goes to `ST_RUN`.

Top module: `supply_reset_seq`

## Requirements
- R1: `sys_rst_n` is 0 in every cycle in which `supply_ok` is 0, including the same cycle the input falls, before any clock edge.
- R2: After `supply_ok` is first sampled 1 at a rising edge, with `tick` high every cycle, `sys_rst_n` stays 0 for that edge and the next HOLD_TICKS-1 edges. It becomes 1 after edge number HOLD_TICKS following it, provided `supply_ok` stays 1.
- R3: If `supply_ok` goes 0 during the hold-off, the tick count is cleared. A full HOLD_TICKS ticks are needed again after the supply recovers.
- R4: The hold-off count advances only at edges where `tick` is 1. Cycles with `tick` at 0 neither count nor release.
- R5: `wdog_expire` sampled 1 while reset is released makes `sys_rst_n` 0 from that edge on. Reset stays low for a hold-off of HOLD_TICKS ticks, with the same timing as R2. `wdog_expire` has no effect while reset is already asserted.
- R6: `wdog_flag` becomes 1 at the edge that takes a watchdog reset, and becomes 0 at any edge where `supply_ok` is 0.
- R7: `flag_set` sets `wdog_flag` and `flag_clr` clears it at the next edge; `flag_clr` wins over `flag_set`. A low-supply clear takes priority over a watchdog set, which in turn takes priority over either strobe.
- R8: While `rst_n` is 0 the block is in `ST_LOWV` with `sys_rst_n` 0 and `wdog_flag` 0.
- R9: A supply dip during a watchdog hold-off turns it into a low-supply reset. The flag is cleared and a full hold-off follows recovery.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer logic |
| tick | input | 1 | Timebase strobe; one hold-off tick per high cycle |
| supply_ok | input | 1 | 1 while the supply is above the trip level (synchronous) |
| wdog_expire | input | 1 | Watchdog timeout request |
| flag_set | input | 1 | Software strobe that sets the cause flag |
| flag_clr | input | 1 | Software strobe that clears the cause flag |
| sys_rst_n | output | 1 | Active-low system reset |
| wdog_flag | output | 1 | 1: latest reset came from the watchdog; 0: from low supply |

## Verification
The hardest situations to reach are those that need a precise position inside the hold-off window:
- a supply dip partway through the count, which must discard the count;
- a dip during the watchdog hold-off, which must convert it into a low-supply reset.

The stimulus reaches these by stepping the inputs one clock at a time from a known state entry and counting edges. Each dip therefore lands on a chosen count value. Runs of cycles with the tick held low show that time without ticks does not shorten the hold-off. Simultaneous strobes and events check the flag priority.

// File: rtl/srs_pkg.sv
package srs_pkg;
    typedef enum logic [1:0] {
        ST_LOWV = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2,
        ST_WDOG = 2'd3
    } srs_state_e;
endpackage

// File: rtl/srs_holdoff_timer.sv
module srs_holdoff_timer #(
    parameter int unsigned HOLD_TICKS = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    input  logic tick,
    output logic hold_done
);
    localparam int unsigned CW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!count_en) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hold_done = count_en && tick && (cnt_q == LAST);

    // Count never passes its terminal value (hold-off length, R2)
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // A pause in counting leaves a cleared count (restart, R3)
    assert_restart_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en |=> cnt_q == '0);
    // No tick, no progress (R4)
    assert_tick_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/srs_cause_flag.sv
module srs_cause_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic lowv_evt,
    input  logic wdog_evt,
    input  logic sw_set,
    input  logic sw_clr,
    output logic flag
);
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (lowv_evt) flag_q <= 1'b0;
        else if (wdog_evt) flag_q <= 1'b1;
        else if (sw_clr)   flag_q <= 1'b0;
        else if (sw_set)   flag_q <= 1'b1;
    end

    assign flag = flag_q;

    assert_lowv_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lowv_evt |=> !flag_q);
    assert_wdog_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_evt && !lowv_evt) |=> flag_q);
    assert_clr_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr && !wdog_evt) |=> !flag_q);
endmodule

// File: rtl/srs_fsm.sv
module srs_fsm
    import srs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic wdog_expire,
    input  logic hold_done,
    output logic count_en,
    output logic released,
    output logic wdog_evt,
    output logic lowv_evt
);
    srs_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOWV: if (supply_ok) state_d = ST_HOLD;
            ST_HOLD: begin
                if (!supply_ok)     state_d = ST_LOWV;
                else if (hold_done) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!supply_ok)       state_d = ST_LOWV;
                else if (wdog_expire) state_d = ST_WDOG;
            end
            ST_WDOG: begin
                if (!supply_ok)     state_d = ST_LOWV;
                else if (hold_done) state_d = ST_RUN;
            end
            default: state_d = ST_LOWV;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOWV;
        else        state_q <= state_d;
    end

    always_comb begin
        count_en = supply_ok && (state_q == ST_HOLD || state_q == ST_WDOG);
        released = (state_q == ST_RUN);
        wdog_evt = (state_q == ST_RUN) && supply_ok && wdog_expire;
        lowv_evt = !supply_ok;
    end

    assert_release_on_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> $past(hold_done));
    assert_wdog_enters_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && supply_ok && wdog_expire) |=> state_q == ST_WDOG);
    assert_wdog_dip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WDOG && !supply_ok) |=> state_q == ST_LOWV);
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
    parameter int unsigned HOLD_TICKS = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic supply_ok,
    input  logic wdog_expire,
    input  logic flag_set,
    input  logic flag_clr,
    output logic sys_rst_n,
    output logic wdog_flag
);
    logic count_en, hold_done, released, wdog_evt, lowv_evt;

    srs_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wdog_expire(wdog_expire),
        .hold_done(hold_done), .count_en(count_en), .released(released),
        .wdog_evt(wdog_evt), .lowv_evt(lowv_evt)
    );

    srs_holdoff_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .count_en(count_en), .tick(tick),
        .hold_done(hold_done)
    );

    srs_cause_flag u_flag (
        .clk(clk), .rst_n(rst_n), .lowv_evt(lowv_evt), .wdog_evt(wdog_evt),
        .sw_set(flag_set), .sw_clr(flag_clr), .flag(wdog_flag)
    );

    // Low supply overrides the registered release without a clock edge (R1)
    assign sys_rst_n = released && supply_ok;

    assert_lowv_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> !sys_rst_n);
    assert_in_reset_R8: assert property (@(posedge clk)
        !rst_n |-> (!sys_rst_n && !wdog_flag));
endmodule

// File: tb/supply_reset_seq_test.sv
module supply_reset_seq_test;
    localparam int unsigned N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1, supply_ok = 1'b0, wdog_expire = 1'b0;
    logic flag_set = 1'b0, flag_clr = 1'b0;
    logic sys_rst_n, wdog_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit    exp_rst_q[$];
    bit    exp_flag_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    supply_reset_seq #(.HOLD_TICKS(N)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
        .wdog_expire(wdog_expire), .flag_set(flag_set), .flag_clr(flag_clr),
        .sys_rst_n(sys_rst_n), .wdog_flag(wdog_flag)
    );

    task automatic check(input string tag, input bit act_r, input bit exp_r,
                         input bit act_f, input bit exp_f);
        checks++;
        if (act_r !== exp_r || act_f !== exp_f) begin
            errors++;
            $display("FAIL %s: sys_rst_n=%0b wdog_flag=%0b expected sys_rst_n=%0b wdog_flag=%0b",
                     tag, act_r, act_f, exp_r, exp_f);
        end
    endtask

    // Driver: apply inputs at the falling edge, queue the outputs expected after the next rising edge
    task automatic step(input bit sup, input bit wd, input bit tk, input bit fs,
                        input bit fc, input bit er, input bit ef, input string tag);
        @(negedge clk);
        supply_ok = sup; wdog_expire = wd; tick = tk; flag_set = fs; flag_clr = fc;
        exp_rst_q.push_back(er);
        exp_flag_q.push_back(ef);
        tag_q.push_back(tag);
    endtask

    // Supply good with ticks: N steps in reset, then released
    task automatic holdoff(input bit ef, input string tag);
        for (int i = 0; i < N; i++) step(1, 0, 1, 0, 0, 0, ef, tag);
        step(1, 0, 1, 0, 0, 1, ef, tag);
    endtask

    // Monitor: compare away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_rst_q.size() > 0)
                check(tag_q.pop_front(), sys_rst_n, exp_rst_q.pop_front(),
                      wdog_flag, exp_flag_q.pop_front());
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R8 reset state", sys_rst_n, 0, wdog_flag, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: supply low keeps reset
        for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 0, 0, "R1 supply low");
        // R2: power-up hold-off
        holdoff(0, "R2 power-up release");
        // R5/R6: watchdog reset with same hold-off
        step(1, 1, 1, 0, 0, 0, 1, "R5 wdog asserts reset");
        for (int i = 0; i < N - 1; i++) step(1, 0, 1, 0, 0, 0, 1, "R5 wdog hold-off");
        step(1, 0, 1, 0, 0, 1, 1, "R6 wdog release flag kept");
        // R7: software strobes
        step(1, 0, 1, 0, 1, 1, 0, "R7 sw clear");
        step(1, 0, 1, 1, 0, 1, 1, "R7 sw set");
        step(1, 0, 1, 1, 1, 1, 0, "R7 clear wins over set");
        step(1, 0, 1, 1, 0, 1, 1, "R7 sw set again");
        // R1 immediacy and R6 low-supply clear
        @(negedge clk);
        supply_ok = 1'b0;
        #1;
        check("R1 immediate assert", sys_rst_n, 0, wdog_flag, 1);
        exp_rst_q.push_back(0); exp_flag_q.push_back(0); tag_q.push_back("R6 low supply clears flag");
        // R3: dip after 5 ticks restarts
        step(1, 0, 1, 0, 0, 0, 0, "R3 enter hold-off");
        for (int i = 0; i < 5; i++) step(1, 0, 1, 0, 0, 0, 0, "R3 partial count");
        step(0, 0, 1, 0, 0, 0, 0, "R3 dip");
        holdoff(0, "R3 full restart");
        // R4: no ticks, no progress
        step(0, 0, 1, 0, 0, 0, 0, "R4 dip");
        step(1, 0, 0, 0, 0, 0, 0, "R4 enter hold-off");
        for (int i = 0; i < 20; i++) step(1, 0, 0, 0, 0, 0, 0, "R4 tick idle");
        for (int i = 0; i < N - 1; i++) step(1, 0, 1, 0, 0, 0, 0, "R4 ticking");
        step(1, 0, 1, 0, 0, 1, 0, "R4 release after ticks");
        // R5: watchdog ignored while in reset
        step(0, 0, 1, 0, 0, 0, 0, "R5 dip");
        step(1, 1, 1, 0, 0, 0, 0, "R5 wdog ignored in reset");
        for (int i = 0; i < N - 1; i++) step(1, 1, 1, 0, 0, 0, 0, "R5 wdog ignored in reset");
        step(1, 0, 1, 0, 0, 1, 0, "R5 release timing unchanged");
        // R7: watchdog set beats sw clear; R9: dip in watchdog hold-off
        step(1, 1, 1, 0, 1, 0, 1, "R7 wdog beats sw clear");
        for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0, 0, 1, "R9 wdog hold-off");
        step(0, 0, 1, 1, 0, 0, 0, "R9 dip clears flag over sw set");
        holdoff(0, "R9 full low-supply hold-off");
        step(1, 0, 1, 0, 0, 1, 0, "R9 stays released");

        repeat (2) @(posedge clk);
        #3;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule